// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between two free-running clocks that may be unrelated or may be the very same clock. The producer writes on the rising edge of its own clock. Two enables of opposite polarity must agree, and the block must be signalling that it can accept data. The consumer sees the oldest stored word already waiting in an output register, together with an output-valid flag in its own clock domain. It pops that word with an active-low read request, which is honoured only while both active-low output enables are asserted.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy reaches the other domain through a two-flop synchronizer. Full and empty are judged from these synchronized copies. The read side forwards a "consumed" pointer, so a word sitting in the output register still occupies a slot until it is actually taken. The total capacity is therefore exactly the memory depth. A single asynchronous active-low reset clears both sides. Each side leaves reset synchronously to its own clock. The high-impedance state of the data pins is represented by an output-drive signal.

Top module: `xfifo_fwft`

## Requirements
- R1: A word is stored on a write-clock rising edge only when `wr_en_a` is 1, `wr_en_b_n` is 0 and `in_ready` is 1; any other combination of the two enables stores nothing.
- R2: `in_ready` is 0 while `rst_n` is 0 and becomes 1 after the second write-clock rising edge following the release of `rst_n`.
- R3: The FIFO holds 64 words, counting the word in the output register. With no reads, exactly 64 of a longer burst of writes are accepted, `in_ready` is then 0, and further write attempts are ignored.
- R4: A word written into an empty FIFO appears on `rd_data` with `out_ready` 1 right after the third read-clock rising edge that follows its write edge (clocks coincident), whatever the levels of `rd_en_n`, `oe_a_n` and `oe_b_n`.
- R5: The word on `rd_data` is consumed on a read-clock rising edge when `out_ready`, `rd_en_n`=0, `oe_a_n`=0 and `oe_b_n`=0 all hold; the next stored word then replaces it, or `out_ready` falls if none is left.
- R6: While `oe_a_n` or `oe_b_n` is 1, no word is consumed (`out_ready` and `rd_data` hold) and `out_drive` is 0; `out_drive` is 1 only when both are 0.
- R7: While `out_ready` is 0, `rd_data` keeps the last word that was consumed.
- R8: Words leave in the order they were accepted, with no loss or duplication, for both coincident and unrelated clocks.
- R9: Driving `rst_n` to 0 immediately forces `out_ready` and `in_ready` to 0 and discards all stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a | input | 1 | Write enable, active high |
| wr_en_b_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word to store |
| in_ready | output | 1 | Space available; write side may store |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| rd_data | output | 18 | Output register holding the head word |
| out_ready | output | 1 | `rd_data` holds a valid unread word |
| out_drive | output | 1 | Data outputs driven (0 models high impedance) |

## Verification
After `rst_n` is released, `in_ready` is due right after the second write edge. A word written into an empty FIFO is due on `rd_data` after the third read edge: one edge to load the write pointer, two synchronizer edges, then the output-register load. The bench counts those edges from the write edge and samples at falling edges, so the edge before the expected one shows the old value and the expected one shows the new value. A pop takes effect on the rising edge after the request is seen. The scoreboard monitor therefore compares the head word at the falling edge where the pop condition holds, one half-cycle before the word leaves. Hold and ignore cases are checked after several further edges, at the ports.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int unsigned XFIFO_DATA_W = 18;
  localparam int unsigned XFIFO_ADDR_W = 6;
  localparam int unsigned XFIFO_SYNC_N = 2;
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_req,
  input  logic [ADDR_W:0]   cons_gray_s,
  output logic              in_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W:0]   wbin,
  output logic [ADDR_W:0]   wgray
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic          full;
  logic          accept;

  // Full: write pointer is one lap ahead of the consumed pointer.
  assign full     = (wgray_q == {~cons_gray_s[PW-1:PW-2], cons_gray_s[PW-3:0]});
  assign in_ready = srst_n & ~full;
  assign accept   = wr_req & in_ready;

  always_comb begin
    wbin_d  = wbin_q + {{(PW-1){1'b0}}, accept};
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (accept) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign mem_we    = accept;
  assign mem_waddr = wbin_q[ADDR_W-1:0];
  assign wbin      = wbin_q;
  assign wgray     = wgray_q;
endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [ADDR_W:0]   rbin,
  output logic [ADDR_W:0]   cons_gray
);
  localparam int unsigned PW = ADDR_W + 1;

  logic [PW-1:0]     rbin_q, rbin_d;
  logic [PW-1:0]     rgray_q, rgray_d;
  logic [PW-1:0]     cgray_q, cgray_d;
  logic [PW-1:0]     cbin_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              valid_q, valid_d;
  logic              empty, take, load;

  assign empty = (rgray_q == wgray_s);
  assign take  = valid_q & pop_req;
  assign load  = ~empty & (~valid_q | take);

  always_comb begin
    rbin_d  = rbin_q + {{(PW-1){1'b0}}, load};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    if (load)      valid_d = 1'b1;
    else if (take) valid_d = 1'b0;
    else           valid_d = valid_q;
    dout_d  = load ? mem_rdata : dout_q;
    // A word parked in the output register still holds its slot.
    cbin_d  = rbin_d - {{(PW-1){1'b0}}, valid_d};
    cgray_d = cbin_d ^ (cbin_d >> 1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      cgray_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      cgray_q <= cgray_d;
      valid_q <= valid_d;
      if (load) dout_q <= dout_d;
    end
  end

  assign mem_raddr = rbin_q[ADDR_W-1:0];
  assign out_data  = dout_q;
  assign out_valid = valid_q;
  assign rbin      = rbin_q;
  assign cons_gray = cgray_q;
endmodule

// File: rtl/xfifo_fwft.sv
module xfifo_fwft
  import xfifo_pkg::*;
#(
  parameter int unsigned DATA_W = XFIFO_DATA_W,
  parameter int unsigned ADDR_W = XFIFO_ADDR_W,
  parameter int unsigned SYNC_N = XFIFO_SYNC_N
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_a,
  input  logic              wr_en_b_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_ready,
  input  logic              rd_en_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_ready,
  output logic              out_drive
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wr_srst_n, rd_srst_n;
  logic              wr_req, pop_req;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [PW-1:0]     wr_ptr_bin, wr_ptr_gray, wr_ptr_gray_s;
  logic [PW-1:0]     rd_ptr_bin, cons_gray, cons_gray_s;

  assign wr_req    = wr_en_a & ~wr_en_b_n;
  assign out_drive = ~oe_a_n & ~oe_b_n;
  assign pop_req   = ~rd_en_n & out_drive;

  xfifo_rst_sync #(.STAGES(SYNC_N)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n)
  );
  xfifo_rst_sync #(.STAGES(SYNC_N)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n)
  );

  xfifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_ptr_gray), .q(wr_ptr_gray_s)
  );
  xfifo_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(cons_gray), .q(cons_gray_s)
  );

  xfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .srst_n(wr_srst_n), .wr_req(wr_req),
    .cons_gray_s(cons_gray_s), .in_ready(in_ready), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .wbin(wr_ptr_bin), .wgray(wr_ptr_gray)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  xfifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .srst_n(rd_srst_n), .wgray_s(wr_ptr_gray_s),
    .pop_req(pop_req), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .out_data(rd_data), .out_valid(out_ready), .rbin(rd_ptr_bin),
    .cons_gray(cons_gray)
  );
endmodule

// File: rtl/xfifo_fwft_chk.sv
module xfifo_fwft_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_en_a,
  input logic              wr_en_b_n,
  input logic              in_ready,
  input logic              oe_a_n,
  input logic              oe_b_n,
  input logic              out_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wr_ptr_bin,
  input logic [ADDR_W:0]   rd_ptr_bin
);
  // R1: without both write enables agreeing, the write pointer does not move
  a_r1_qualified_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(wr_en_a && !wr_en_b_n) |=> $stable(wr_ptr_bin));

  // R3: a write attempt while not ready leaves the pointer alone
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!in_ready && wr_en_a && !wr_en_b_n) |=> $stable(wr_ptr_bin));

  // R2: not ready during reset
  a_r2_idle_in_reset: assert property (@(posedge wr_clk)
    !rst_n |-> !in_ready);

  // R9: no valid output during reset
  a_r9_empty_in_reset: assert property (@(posedge rd_clk)
    !rst_n |-> !out_ready);

  // R6: output disabled blocks consumption
  a_r6_blocked_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (out_ready && (oe_a_n || oe_b_n)) |=> (out_ready && $stable(rd_data)));

  // R7: data held while no valid word
  a_r7_hold_last: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !out_ready |=> (out_ready || $stable(rd_data)));

  // R8: read pointer advances by at most one word per edge
  a_r8_single_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> (rd_ptr_bin == $past(rd_ptr_bin)) ||
             (rd_ptr_bin == $past(rd_ptr_bin) + 1'b1));
endmodule

bind xfifo_fwft xfifo_fwft_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_a(wr_en_a),
  .wr_en_b_n(wr_en_b_n), .in_ready(in_ready), .oe_a_n(oe_a_n),
  .oe_b_n(oe_b_n), .out_ready(out_ready), .rd_data(rd_data),
  .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin)
);

// File: tb/tb_xfifo_fwft.sv
module tb_xfifo_fwft;
  localparam int CLK_PERIOD = 10;
  localparam int RD_HALF    = 7;
  localparam int WATCHDOG   = 60000;

  logic wr_clk, rd_own, rd_clk, async_mode;
  logic rst_n, wr_en_a, wr_en_b_n, rd_en_n, oe_a_n, oe_b_n;
  logic [17:0] wr_data;
  logic in_ready, out_ready, out_drive;
  logic [17:0] rd_data;

  int total, bad, n_pop, acc;
  logic [17:0] sb_q [$];
  logic [17:0] first_word;

  xfifo_fwft dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_a(wr_en_a),
    .wr_en_b_n(wr_en_b_n), .wr_data(wr_data), .in_ready(in_ready),
    .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .rd_data(rd_data),
    .out_ready(out_ready), .out_drive(out_drive)
  );

  initial begin
    wr_clk = 1'b0;
    forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  end
  initial begin
    rd_own = 1'b0;
    forever #(RD_HALF) rd_own = ~rd_own;
  end
  assign rd_clk = async_mode ? rd_own : wr_clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: the head word is compared when a pop condition is seen.
  initial begin
    forever begin
      @(negedge rd_clk);
      if (out_ready && !rd_en_n && !oe_a_n && !oe_b_n) begin
        total++;
        if (sb_q.size() == 0) begin
          bad++;
          $display("FAIL R5 R8 actual=%0h expected=<nothing queued>", rd_data);
        end else begin
          if (rd_data !== sb_q[0]) begin
            bad++;
            $display("FAIL R5 R8 actual=%0h expected=%0h", rd_data, sb_q[0]);
          end
          void'(sb_q.pop_front());
        end
        n_pop++;
      end
    end
  end

  task automatic do_write(input logic [17:0] d, input logic a, input logic bn);
    @(posedge wr_clk); #1;
    wr_data = d; wr_en_a = a; wr_en_b_n = bn;
    @(negedge wr_clk);
    if (a && !bn && in_ready) begin
      sb_q.push_back(d);
      acc++;
    end
  endtask

  task automatic idle_write();
    @(posedge wr_clk); #1;
    wr_en_a = 1'b0; wr_en_b_n = 1'b1;
  endtask

  task automatic set_rd(input logic en_n, input logic a_n, input logic b_n);
    @(posedge rd_clk); #1;
    rd_en_n = en_n; oe_a_n = a_n; oe_b_n = b_n;
  endtask

  task automatic drain();
    for (int k = 0; k < 600 && sb_q.size() != 0; k++) @(negedge rd_clk);
    repeat (4) @(negedge rd_clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge wr_clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; n_pop = 0; acc = 0;
    async_mode = 1'b0;
    rst_n = 1'b0; wr_en_a = 1'b0; wr_en_b_n = 1'b1; wr_data = '0;
    rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;

    // R2 / R9: reset state
    repeat (6) @(posedge wr_clk);
    @(negedge wr_clk);
    check("R2 in_ready in reset", in_ready, 0);
    check("R9 out_ready in reset", out_ready, 0);
    rst_n = 1'b1;
    @(negedge wr_clk);
    check("R2 in_ready after 1 edge", in_ready, 0);
    @(negedge wr_clk);
    check("R2 in_ready after 2 edges", in_ready, 1);

    // R1: wrong qualifier combinations store nothing
    do_write(18'h00111, 1'b0, 1'b0);
    do_write(18'h00222, 1'b1, 1'b1);
    do_write(18'h00333, 1'b0, 1'b1);
    idle_write();
    repeat (6) @(negedge rd_clk);
    check("R1 nothing stored", out_ready, 0);

    // R4: fall-through timing, reads and outputs disabled
    first_word = 18'h1A5A5;
    do_write(first_word, 1'b1, 1'b0);
    idle_write();
    @(negedge rd_clk);
    @(negedge rd_clk);
    @(negedge rd_clk);
    check("R4 out_ready before third edge", out_ready, 0);
    @(negedge rd_clk);
    check("R4 out_ready at third edge", out_ready, 1);
    check("R4 word on output", rd_data, first_word);

    // R6: either output enable high blocks reads
    check("R6 out_drive off", out_drive, 0);
    set_rd(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge rd_clk);
    check("R6 blocked by oe_a_n valid", out_ready, 1);
    check("R6 blocked by oe_a_n data", rd_data, first_word);
    set_rd(1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge rd_clk);
    check("R6 out_drive off b", out_drive, 0);
    check("R6 blocked by oe_b_n valid", out_ready, 1);

    // R5 / R7: enable reading, word consumed, output holds it
    set_rd(1'b0, 1'b0, 1'b0);
    repeat (6) @(negedge rd_clk);
    check("R6 out_drive on", out_drive, 1);
    check("R5 word consumed", out_ready, 0);
    check("R7 last word held", rd_data, first_word);
    for (int i = 0; i < 5; i++) do_write(18'h2A000 + 18'(i), 1'b1, 1'b0);
    idle_write();
    drain();
    check("R5 stream drained", sb_q.size(), 0);
    check("R7 last of stream held", rd_data, 18'h2A004);

    // R3: capacity with reads off
    set_rd(1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge rd_clk);
    acc = 0;
    for (int i = 0; i < 70; i++) do_write(18'h00100 + 18'(i), 1'b1, 1'b0);
    idle_write();
    repeat (4) @(negedge wr_clk);
    check("R3 accepted count", acc, 64);
    check("R3 in_ready full", in_ready, 0);
    n_pop = 0;
    set_rd(1'b0, 1'b0, 1'b0);
    drain();
    check("R3 popped count", n_pop, 64);
    check("R3 in_ready after drain", in_ready, 1);

    // R8: unrelated clocks, irregular reading
    async_mode = 1'b1;
    repeat (4) @(negedge rd_clk);
    fork
      begin
        for (int i = 0; i < 48; i++) begin
          do_write(18'h30000 + 18'(i * 7), 1'b1, 1'b0);
          if (i % 5 == 4) idle_write();
        end
        idle_write();
      end
      begin
        for (int j = 0; j < 90; j++) set_rd((j % 3) == 1, 1'b0, (j % 7) == 3);
        set_rd(1'b0, 1'b0, 1'b0);
      end
    join
    drain();
    check("R8 async stream drained", sb_q.size(), 0);

    // R9: reset in mid-stream discards contents
    set_rd(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) do_write(18'h05500 + 18'(i), 1'b1, 1'b0);
    idle_write();
    repeat (6) @(negedge rd_clk);
    #3 rst_n = 1'b0;
    #1;
    check("R9 out_ready cleared", out_ready, 0);
    check("R9 in_ready cleared", in_ready, 0);
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    sb_q.delete();
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (8) @(negedge rd_clk);
    check("R9 nothing left after reset", out_ready, 0);
    set_rd(1'b0, 1'b0, 1'b0);
    do_write(18'h2BEEF, 1'b1, 1'b0);
    idle_write();
    drain();
    check("R9 only new word seen", sb_q.size(), 0);
    check("R9 new word held", rd_data, 18'h2BEEF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule